// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers interrupt events from a set of peripheral sources and decides, each time the CPU finishes an instruction, whether one of them should interrupt it. Every source has a request flag, a mask bit and a 4-bit urgency value. A per-source event enable decides whether an event sets the flag at all. Among the sources that are allowed to interrupt, the most urgent one is compared with the CPU's current interrupt mask level. That level is taken from bits 7:4 of a status word the CPU supplies.

When a source wins, the block raises a request line. With it, the block gives the fixed vector number wired to that source and the winning urgency, so that the CPU can raise its mask level to that value. The request stays up until the CPU acknowledges it. Software configures and inspects the block through a small register port. Flags are cleared by writing ones to the flag register.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every mask bit is 1 (blocked), every event enable is 0, every flag is 0, every urgency value is 0, and irq_req is 0.
- R2: A source event sets that source's flag on the next clock only when the source's event enable bit is 1. With the enable at 0, the flag keeps its value.
- R3: Writing the flag register (address 2) clears each flag whose data bit is 1. If an enabled event for that source arrives in the same cycle, the flag ends up set.
- R4: A source is eligible only when its flag is 1, its mask bit is 0 and its urgency is nonzero. Urgency 0 blocks the source whatever its mask bit.
- R5: An eligible source can interrupt only when its urgency is strictly greater than status_word bits 7:4.
- R6: Requests are evaluated only in a cycle where insn_boundary is 1. irq_req, irq_vector and irq_level update at the clock edge that ends that cycle.
- R7: Among the qualifying sources, the highest urgency wins. On equal urgency, the lower source index wins.
- R8: On acceptance, irq_vector equals VEC_BASE plus the winning source index, and irq_level equals its urgency.
- R9: While irq_req is 1, the request, vector and level hold and boundaries are ignored. An irq_ack in that state drops irq_req on the next clock, and that cycle's boundary is not evaluated either.
- R10: Register map. Address 0 is the mask, one bit per source. Address 1 is the event enable, one bit per source. Address 2 is the flags. Address 4+j holds urgency values for sources 4j to 4j+3, with source 4j+n in bits 4n+3:4n. All other addresses read as 0. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_event | input | N_SRC | One event pulse per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| status_word | input | SR_W | CPU status word; bits 7:4 hold the mask level |
| insn_boundary | input | 1 | Strobe marking a completed instruction |
| irq_ack | input | 1 | CPU acknowledge of the pending request |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vector | output | VEC_W | Vector number of the accepted source |
| irq_level | output | 4 | Urgency of the accepted source |

## Verification
Two pairs of functions can land in the same clock. The first is a source event against a write-one clear of the same flag. The second is an acknowledge against an instruction boundary while a request is held. The bench drives each pair together on purpose, both in directed steps and in a long random phase. The behavioural model settles each collision by the rule in R3 and R9, and it is compared with the flag readback and the request outputs on every clock.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   localparam int ADDR_MASK  = 0;
   localparam int ADDR_EN    = 1;
   localparam int ADDR_FLAG  = 2;
   localparam int ADDR_PRIO0 = 4;
   localparam int PRIO_W     = 4;
   localparam int LVL_LSB    = 4;
   typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
   parameter int N_SRC  = 8,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 4
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                we,
   input  logic [ADDR_W-1:0]                   addr,
   input  logic [DATA_W-1:0]                   wdata,
   output logic [N_SRC-1:0]                    mask,
   output logic [N_SRC-1:0]                    en,
   output irq_ctrl_pkg::prio_t [N_SRC-1:0]     prio
);
   import irq_ctrl_pkg::*;
   localparam int PPW = DATA_W / PRIO_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask <= '1;
         en   <= '0;
      end else if (we) begin
         if (addr == ADDR_W'(ADDR_MASK)) mask <= wdata[N_SRC-1:0];
         if (addr == ADDR_W'(ADDR_EN))   en   <= wdata[N_SRC-1:0];
      end
   end

   for (genvar k = 0; k < N_SRC; k++) begin : g_prio
      localparam int WORD = k / PPW;
      localparam int NIB  = k % PPW;
      always_ff @(posedge clk) begin
         if (!rst_n) prio[k] <= '0;
         else if (we && addr == ADDR_W'(ADDR_PRIO0 + WORD))
            prio[k] <= wdata[NIB*PRIO_W +: PRIO_W];
      end
   end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int N_SRC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] evt,
   input  logic [N_SRC-1:0] en,
   input  logic [N_SRC-1:0] clr,
   output logic [N_SRC-1:0] flags
);
   always_ff @(posedge clk) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr) | (evt & en);
   end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int N_SRC = 8,
   parameter int IDX_W = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0]                flags,
   input  logic [N_SRC-1:0]                mask,
   input  irq_ctrl_pkg::prio_t [N_SRC-1:0] prio,
   input  irq_ctrl_pkg::prio_t             cur_lvl,
   output logic                            hit,
   output logic [IDX_W-1:0]                win_idx,
   output irq_ctrl_pkg::prio_t             win_prio
);
   logic [N_SRC-1:0] qual;

   for (genvar k = 0; k < N_SRC; k++) begin : g_qual
      assign qual[k] = flags[k] && !mask[k] && (prio[k] != '0) && (prio[k] > cur_lvl);
   end

   always_comb begin
      hit      = 1'b0;
      win_idx  = '0;
      win_prio = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (qual[i] && prio[i] > win_prio) begin
            hit      = 1'b1;
            win_idx  = IDX_W'(i);
            win_prio = prio[i];
         end
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int N_SRC    = 8,
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 4,
   parameter int SR_W     = 32,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_event,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [SR_W-1:0]   status_word,
   input  logic              insn_boundary,
   input  logic              irq_ack,
   output logic              irq_req,
   output logic [VEC_W-1:0]  irq_vector,
   output logic [3:0]        irq_level
);
   import irq_ctrl_pkg::*;
   localparam int PPW   = DATA_W / PRIO_W;
   localparam int N_PW  = (N_SRC + PPW - 1) / PPW;
   localparam int IDX_W = $clog2(N_SRC);

   if (N_SRC < 2 || N_SRC > DATA_W) begin : g_bad_src
      $error("N_SRC must lie in 2..DATA_W");
   end
   if (DATA_W % PRIO_W != 0) begin : g_bad_data
      $error("DATA_W must be a multiple of 4");
   end
   if (ADDR_PRIO0 + N_PW > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for urgency words");
   end
   if (VEC_BASE + N_SRC > (1 << VEC_W)) begin : g_bad_vec
      $error("vector range exceeds VEC_W");
   end
   if (SR_W < 8) begin : g_bad_sr
      $error("status word must hold bits 7:4");
   end

   logic [N_SRC-1:0] mask_q, en_q, flag_q, clr_vec;
   prio_t [N_SRC-1:0] prio_q;
   logic              win_hit;
   logic [IDX_W-1:0]  win_idx;
   prio_t             win_prio, cur_lvl;
   logic              unused_sr;

   assign cur_lvl   = status_word[LVL_LSB +: PRIO_W];
   assign unused_sr = ^{status_word[SR_W-1:LVL_LSB+PRIO_W], status_word[LVL_LSB-1:0]};
   assign clr_vec   = (reg_we && reg_addr == ADDR_W'(ADDR_FLAG)) ? reg_wdata[N_SRC-1:0] : '0;

   irq_cfg_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_cfg (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .mask(mask_q), .en(en_q), .prio(prio_q));

   irq_flag_bank #(.N_SRC(N_SRC)) i_flags (
      .clk(clk), .rst_n(rst_n), .evt(src_event), .en(en_q), .clr(clr_vec), .flags(flag_q));

   irq_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) i_arb (
      .flags(flag_q), .mask(mask_q), .prio(prio_q), .cur_lvl(cur_lvl),
      .hit(win_hit), .win_idx(win_idx), .win_prio(win_prio));

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(ADDR_MASK)) reg_rdata[N_SRC-1:0] = mask_q;
      if (reg_addr == ADDR_W'(ADDR_EN))   reg_rdata[N_SRC-1:0] = en_q;
      if (reg_addr == ADDR_W'(ADDR_FLAG)) reg_rdata[N_SRC-1:0] = flag_q;
      for (int k = 0; k < N_SRC; k++) begin
         if (reg_addr == ADDR_W'(ADDR_PRIO0 + k / PPW))
            reg_rdata[(k % PPW)*PRIO_W +: PRIO_W] = prio_q[k];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_req    <= 1'b0;
         irq_vector <= '0;
         irq_level  <= '0;
      end else if (irq_req) begin
         if (irq_ack) irq_req <= 1'b0;
      end else if (insn_boundary && win_hit) begin
         irq_req    <= 1'b1;
         irq_vector <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
         irq_level  <= win_prio;
      end
   end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
   parameter int N_SRC    = 8,
   parameter int SR_W     = 32,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_SRC-1:0] src_event,
   input logic [SR_W-1:0]  status_word,
   input logic             insn_boundary,
   input logic             irq_ack,
   input logic             irq_req,
   input logic [VEC_W-1:0] irq_vector,
   input logic [3:0]       irq_level,
   input logic [N_SRC-1:0] flags,
   input logic [N_SRC-1:0] evt_en,
   input logic [N_SRC-1:0] clr_vec
);
   AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags & ~$past(flags) & ~$past(src_event & evt_en)) == '0)); // R2
   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      |(src_event & evt_en) |=> ((flags & $past(src_event & evt_en)) == $past(src_event & evt_en))); // R3
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      |clr_vec |=> ((flags & $past(clr_vec) & ~$past(src_event & evt_en)) == '0)); // R3
   AST_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> irq_level != 4'd0); // R4
   AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> irq_level > $past(status_word[7:4])); // R5
   AST_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req && !insn_boundary |=> !irq_req); // R6
   AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (int'(irq_vector) >= VEC_BASE) && (int'(irq_vector) < VEC_BASE + N_SRC)); // R8
   AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && !irq_ack |=> irq_req && $stable(irq_vector) && $stable(irq_level)); // R9
   AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && irq_ack |=> !irq_req); // R9
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(
   .N_SRC(N_SRC), .SR_W(SR_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .src_event(src_event), .status_word(status_word),
   .insn_boundary(insn_boundary), .irq_ack(irq_ack), .irq_req(irq_req),
   .irq_vector(irq_vector), .irq_level(irq_level), .flags(flag_q),
   .evt_en(en_q), .clr_vec(clr_vec)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
   localparam int N = 8, DW = 16, AW = 4, SRW = 32, VW = 8, VB = 64;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n = 1'b0;
   logic [N-1:0]  src_event = '0;
   logic          reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [SRW-1:0] status_word = '0;
   logic          insn_boundary = 1'b0, irq_ack = 1'b0;
   logic          irq_req;
   logic [VW-1:0] irq_vector;
   logic [3:0]    irq_level;

   prio_irq_ctrl #(.N_SRC(N), .DATA_W(DW), .ADDR_W(AW), .SR_W(SRW), .VEC_W(VW), .VEC_BASE(VB))
   i_prio_irq_ctrl (.*);

   int errors = 0, checks = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   task automatic chk(bit ok, string tag, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Behavioural reference model
   bit m_flag[N], m_mask[N], m_en[N];
   int m_prio[N];
   bit m_req = 1'b0;
   int m_vec = 0, m_lvl = 0;

   always @(posedge clk) begin : mdl
      int best, bp, lvl;
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            m_flag[i] = 0; m_mask[i] = 1; m_en[i] = 0; m_prio[i] = 0;
         end
         m_req = 0; m_vec = 0; m_lvl = 0;
      end else begin
         best = -1; bp = 0; lvl = int'(status_word[7:4]);
         for (int i = 0; i < N; i++)
            if (m_flag[i] && !m_mask[i] && m_prio[i] > lvl && m_prio[i] > bp) begin
               best = i; bp = m_prio[i];
            end
         if (m_req) begin
            if (irq_ack) m_req = 0;
         end else if (insn_boundary && best >= 0) begin
            m_req = 1; m_vec = VB + best; m_lvl = bp;
         end
         for (int i = 0; i < N; i++) begin
            if (src_event[i] && m_en[i]) m_flag[i] = 1;
            else if (reg_we && reg_addr == 2 && reg_wdata[i]) m_flag[i] = 0;
         end
         if (reg_we) begin
            for (int i = 0; i < N; i++) begin
               if (reg_addr == 0) m_mask[i] = reg_wdata[i];
               if (reg_addr == 1) m_en[i] = reg_wdata[i];
               if (int'(reg_addr) == 4 + i / 4) m_prio[i] = int'(reg_wdata[(i % 4)*4 +: 4]);
            end
         end
      end
   end

   function automatic logic [DW-1:0] exp_rd(int a);
      logic [DW-1:0] r = '0;
      for (int i = 0; i < N; i++) begin
         if (a == 0) r[i] = m_mask[i];
         if (a == 1) r[i] = m_en[i];
         if (a == 2) r[i] = m_flag[i];
         if (a == 4 + i / 4) r[(i % 4)*4 +: 4] = 4'(m_prio[i]);
      end
      return r;
   endfunction

   always @(negedge clk) begin
      if (!done) begin
         chk(irq_req === m_req, cur_req, "irq_req vs model", irq_req, m_req);
         if (m_req) begin
            chk(irq_vector === VW'(m_vec), cur_req, "irq_vector vs model", irq_vector, m_vec);
            chk(irq_level === 4'(m_lvl), cur_req, "irq_level vs model", irq_level, m_lvl);
         end
         chk(reg_rdata === exp_rd(int'(reg_addr)), "R10", "reg_rdata vs model",
             reg_rdata, exp_rd(int'(reg_addr)));
      end
   end

   task automatic step();
      @(negedge clk); #1;
   endtask
   task automatic wr(int a, logic [DW-1:0] d);
      reg_we = 1; reg_addr = AW'(a); reg_wdata = d; step(); reg_we = 0;
   endtask
   task automatic ev(logic [N-1:0] v);
      src_event = v; step(); src_event = '0;
   endtask
   task automatic bnd();
      insn_boundary = 1; step(); insn_boundary = 0;
   endtask
   task automatic ack();
      irq_ack = 1; step(); irq_ack = 0;
   endtask
   task automatic set_lvl(int l);
      status_word = '0; status_word[7:4] = 4'(l);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) step();
      rst_n = 1; step();
      // R1: reset values
      cur_req = "R1";
      reg_addr = 0; step();
      chk(reg_rdata == 16'h00FF, "R1", "mask after reset", reg_rdata, 16'h00FF);
      chk(irq_req == 0, "R1", "irq_req after reset", irq_req, 0);
      reg_addr = 4; step();
      chk(reg_rdata == 0, "R1", "urgency after reset", reg_rdata, 0);
      // R2: enable gates events
      cur_req = "R2";
      ev(8'h04); reg_addr = 2; step();
      chk(reg_rdata == 0, "R2", "flag with enable off", reg_rdata, 0);
      wr(1, 16'h00FF); ev(8'h04); reg_addr = 2; step();
      chk(reg_rdata == 16'h0004, "R2", "flag with enable on", reg_rdata, 16'h0004);
      // R4: urgency zero blocks
      cur_req = "R4";
      wr(0, 16'h0000); set_lvl(0); bnd(); step();
      chk(irq_req == 0, "R4", "urgency 0 source", irq_req, 0);
      wr(4, 16'h0500); bnd();
      cur_req = "R8";
      chk(irq_req == 1, "R8", "request raised", irq_req, 1);
      chk(irq_vector == 8'd66, "R8", "vector of source 2", irq_vector, 66);
      chk(irq_level == 4'd5, "R8", "level of source 2", irq_level, 5);
      ack();
      // R5: strict compare against status bits 7:4
      cur_req = "R5";
      set_lvl(5); bnd(); step();
      chk(irq_req == 0, "R5", "urgency equal to mask level", irq_req, 0);
      set_lvl(4); bnd();
      chk(irq_req == 1, "R5", "urgency above mask level", irq_req, 1);
      ack();
      // R6: no evaluation without boundary
      cur_req = "R6";
      set_lvl(0); repeat (3) step();
      chk(irq_req == 0, "R6", "no boundary", irq_req, 0);
      // R3: write-one clear
      cur_req = "R3";
      wr(2, 16'h0004); reg_addr = 2; step();
      chk(reg_rdata == 0, "R3", "flag cleared", reg_rdata, 0);
      // R7: highest urgency, tie to lower index
      cur_req = "R7";
      wr(4, 16'h3070); wr(5, 16'h0700); ev(8'h4A); bnd();
      chk(irq_vector == 8'd65, "R7", "tie goes to source 1", irq_vector, 65);
      chk(irq_level == 4'd7, "R7", "tie level", irq_level, 7);
      // R9: hold while pending, boundary ignored, ack drops
      cur_req = "R9";
      wr(2, 16'h0002); bnd();
      chk(irq_vector == 8'd65, "R9", "held through boundary", irq_vector, 65);
      insn_boundary = 1; irq_ack = 1; step(); insn_boundary = 0; irq_ack = 0;
      chk(irq_req == 0, "R9", "ack with boundary drops", irq_req, 0);
      bnd();
      cur_req = "R7";
      chk(irq_vector == 8'd70, "R7", "next source 6", irq_vector, 70);
      ack();
      // R3: clear and event in the same cycle
      cur_req = "R3";
      wr(2, 16'h00FF);
      reg_we = 1; reg_addr = 2; reg_wdata = 16'h0008; src_event = 8'h08; step();
      reg_we = 0; src_event = '0; reg_addr = 2; step();
      chk(reg_rdata == 16'h0008, "R3", "event beats clear", reg_rdata, 16'h0008);
      // R10: readback of urgency word
      reg_addr = 5; step();
      chk(reg_rdata == 16'h0700, "R10", "urgency word 1", reg_rdata, 16'h0700);
      reg_addr = 3; step();
      chk(reg_rdata == 0, "R10", "unmapped address", reg_rdata, 0);
      // Random phase, collisions included
      cur_req = "R7";
      for (int c = 0; c < 4000; c++) begin
         int pick;
         pick = int'($urandom_range(0, 4));
         reg_we = ($urandom_range(0, 7) == 0);
         reg_addr = AW'(pick < 3 ? pick : pick + 1);
         reg_wdata = DW'($urandom);
         if (reg_addr == 0) reg_wdata[N-1:0] = reg_wdata[N-1:0] & DW'($urandom);
         src_event = N'($urandom & $urandom & $urandom);
         insn_boundary = ($urandom_range(0, 2) == 0);
         irq_ack = ($urandom_range(0, 3) == 0);
         status_word = SRW'($urandom);
         if ($urandom_range(0, 1) == 0) status_word[7:4] = 4'($urandom_range(0, 6));
         step();
      end
      reg_we = 0; src_event = '0; insn_boundary = 0; irq_ack = 0;
      step();
      finish_run();
   end
endmodule